// File: doc/BRIEF.md
# Narrow Parallel Memory Bus Bridge

This block sits between a 32-bit processor memory port and an external parallel bus that carries SRAM and ROM. The bus has a 16-bit data path, a 24-bit address, separate active-low read and write strobes, and two active-low byte-lane strobes. A full-word request becomes two bus cycles. The lower half-word goes first and the upper half-word second. A request that only touches bytes inside one half-word uses a single bus cycle. While the bus cycles run, the processor side stays stalled with ready low. Ready then pulses for one clock, and for reads the assembled data is present in that clock.

Each strobe lasts a programmable number of extra clocks, so the bus can run several times slower than the core clock. After reset the extra-clock count is 15, which gives long cycles that suit slow boot ROM. Software can later write a smaller count through a one-cycle configuration strobe to get fast SRAM cycles. The count in effect for a transaction is captured when that transaction is accepted, so a configuration write never changes a bus cycle that is already running.

Top module: `membus_bridge`

## Requirements
- R1: While reset is asserted and once it has been released with no request, ext_rd_n, ext_wr_n, ext_uds_n and ext_lds_n are high, req_ready is low and the data bus is not driven.
- R2: The external address is the internal address bits 23..2, then the half-word index in bit 1 (0 for the lower half, 1 for the upper half), then 0 in bit 0. Internal address bits 31..24 and 1..0 have no effect. When both halves are accessed, the lower half is accessed first.
- R3: Each bus cycle holds its strobe low for W+1 clocks, where W is the captured wait count, and is followed by one clock with all strobes high. The request is accepted on the first clock edge at which req_valid is high and the bridge is idle. req_ready goes high for exactly one clock, N*(W+2)+1 clocks after that acceptance edge, where N is the number of bus cycles.
- R4: The wait count is 15 after reset. A clock with cfg_we high loads cfg_wait. The count used by a transaction is the value held at its acceptance, so a load during a transaction affects only later transactions.
- R5: With byte enables req_be (bit i selects bits 8i+7..8i), the lower half takes part when req_be[1:0] is nonzero and the upper half when req_be[3:2] is nonzero. Only the halves that take part get a bus cycle. req_be = 0 is treated as 4'b1111.
- R6: During a bus cycle of half h, ext_lds_n is low exactly when enable bit 2h is set (data bits 7..0) and ext_uds_n is low exactly when enable bit 2h+1 is set (data bits 15..8). Both are high outside bus cycles.
- R7: A write drives req_wdata bits 16h+15..16h onto the data bus while ext_wr_n is low and for one clock after it rises. The bus is released at all other times.
- R8: ext_rd_n and ext_wr_n are never low together.
- R9: For reads, each accessed half is captured in the last clock of its strobe and placed in rsp_rdata bits 16h+15..16h. A half that is not accessed reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| cfg_we | input | 1 | Load wait count |
| cfg_wait | input | 4 | New wait count |
| ext_addr | output | 24 | External byte address |
| ext_data | inout | 16 | External data bus |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_uds_n | output | 1 | Upper byte lane strobe, active low |
| ext_lds_n | output | 1 | Lower byte lane strobe, active low |

## Verification
The situation hardest to reach from the ports is a wait-count load that lands while a transaction is already on the bus. The count must then apply to the next transaction and not to the current one. The bench pulses cfg_we two clocks after a request is accepted, then measures the length of the current transaction and of the one after it. The other difficult cases are enable patterns that skip the lower half or straddle the two halves. A sweep over all sixteen enable values at several wait counts covers them. Each write is followed by reads, and the bus cycles are recorded so that their order, lanes and lengths can be checked.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } bus_st_t;
endpackage

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter int NHALF = 2,
  parameter int WAITW = 4,
  localparam int HIW = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NHALF-1:0] need,
  input  logic [WAITW-1:0] wait_val,
  output bus_st_t          st,
  output logic [HIW-1:0]   half,
  output logic             last_clk
);

  bus_st_t          st_q, st_d;
  logic [HIW-1:0]   half_q, half_d;
  logic [NHALF-1:0] pend_q, pend_d;
  logic [WAITW-1:0] cnt_q, cnt_d;
  logic [WAITW-1:0] wait_q, wait_d;

  // lowest set index of a half mask
  function automatic logic [HIW-1:0] low_idx(input logic [NHALF-1:0] m);
    logic [HIW-1:0] r;
    r = '0;
    for (int i = NHALF - 1; i >= 0; i--) begin
      if (m[i]) r = HIW'(i);
    end
    return r;
  endfunction

  always_comb begin
    st_d   = st_q;
    half_d = half_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    wait_d = wait_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          half_d = low_idx(need);
          pend_d = need & ~(NHALF'(1) << low_idx(need));
          cnt_d  = wait_val;
          wait_d = wait_val;
          st_d   = ST_STRB;
        end
      end
      ST_STRB: begin
        if (cnt_q == '0) st_d = ST_HOLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        if (|pend_q) begin
          half_d = low_idx(pend_q);
          pend_d = pend_q & ~(NHALF'(1) << low_idx(pend_q));
          cnt_d  = wait_q;
          st_d   = ST_STRB;
        end else begin
          st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      wait_q <= '0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
    end
  end

  assign st       = st_q;
  assign half     = half_q;
  assign last_clk = (st_q == ST_STRB) && (cnt_q == '0);

endmodule

// File: rtl/membus_dp.sv
module membus_dp
  import membus_pkg::*;
#(
  parameter int AWI   = 32,
  parameter int AWE   = 24,
  parameter int DW    = 32,
  parameter int BW    = 16,
  localparam int NHALF = DW / BW,
  localparam int HIW   = (NHALF > 1) ? $clog2(NHALF) : 1,
  localparam int BL    = BW / 8,
  localparam int NBE   = DW / 8,
  localparam int OFFW  = $clog2(BL),
  localparam int WAW   = AWE - OFFW - HIW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_write,
  input  logic [AWI-1:0]   req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [NBE-1:0]   req_be,
  input  bus_st_t          st,
  input  logic [HIW-1:0]   half,
  input  logic             last_clk,
  input  logic [BW-1:0]    din,
  output logic [NHALF-1:0] need,
  output logic [AWE-1:0]   ext_addr,
  output logic [BW-1:0]    dout,
  output logic             oe,
  output logic             rd_n,
  output logic             wr_n,
  output logic [BL-1:0]    lane_n,
  output logic [DW-1:0]    rdata
);

  logic [NBE-1:0] be_eff;
  logic           wr_q;
  logic [WAW-1:0] wa_q;
  logic [DW-1:0]  wd_q;
  logic [NBE-1:0] be_q;
  logic [DW-1:0]  rd_q, rd_d;
  logic           cap_en;
  logic           unused_addr;

  assign be_eff = (req_be == '0) ? '1 : req_be;
  assign unused_addr = ^{req_addr[AWI-1:AWE], req_addr[OFFW+HIW-1:0]};

  for (genvar h = 0; h < NHALF; h++) begin : g_need
    assign need[h] = |be_eff[h*BL +: BL];
  end

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
      be_q <= '0;
    end else if (start) begin
      wr_q <= req_write;
      wa_q <= req_addr[AWE-1:OFFW+HIW];
      wd_q <= req_wdata;
      be_q <= be_eff;
    end
  end

  assign cap_en = last_clk && !wr_q;

  always_comb begin
    rd_d = rd_q;
    if (start)       rd_d = '0;
    else if (cap_en) rd_d[half*BW +: BW] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign ext_addr = {wa_q, half, {OFFW{1'b0}}};
  assign dout     = wd_q[half*BW +: BW];
  assign oe       = wr_q && ((st == ST_STRB) || (st == ST_HOLD));
  assign rd_n     = !((st == ST_STRB) && !wr_q);
  assign wr_n     = !((st == ST_STRB) && wr_q);
  assign lane_n   = (st == ST_STRB) ? ~be_q[half*BL +: BL] : '1;
  assign rdata    = rd_q;

endmodule

// File: rtl/membus_bridge.sv
module membus_bridge
  import membus_pkg::*;
#(
  parameter int AWI      = 32,
  parameter int AWE      = 24,
  parameter int DW       = 32,
  parameter int BW       = 16,
  parameter int WAITW    = 4,
  parameter int WAIT_RST = 15,
  localparam int NHALF   = DW / BW,
  localparam int HIW     = (NHALF > 1) ? $clog2(NHALF) : 1,
  localparam int NBE     = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AWI-1:0]   req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [NBE-1:0]   req_be,
  output logic             req_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             cfg_we,
  input  logic [WAITW-1:0] cfg_wait,
  output logic [AWE-1:0]   ext_addr,
  inout  wire  [BW-1:0]    ext_data,
  output logic             ext_rd_n,
  output logic             ext_wr_n,
  output logic             ext_uds_n,
  output logic             ext_lds_n
);

  logic [1:0]       rsync_q;
  logic             rst_s_n;
  logic [WAITW-1:0] wait_cfg_q;
  logic             start;
  bus_st_t          st;
  logic [HIW-1:0]   half;
  logic             last_clk;
  logic [NHALF-1:0] need;
  logic [BW-1:0]    dat_out;
  logic             dat_oe;
  logic [BW/8-1:0]  lane_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    wait_cfg_q <= WAITW'(WAIT_RST);
    else if (cfg_we) wait_cfg_q <= cfg_wait;
  end

  assign start = req_valid && (st == ST_IDLE);

  membus_seq #(.NHALF(NHALF), .WAITW(WAITW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (start),
    .need     (need),
    .wait_val (wait_cfg_q),
    .st       (st),
    .half     (half),
    .last_clk (last_clk)
  );

  membus_dp #(.AWI(AWI), .AWE(AWE), .DW(DW), .BW(BW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .st        (st),
    .half      (half),
    .last_clk  (last_clk),
    .din       (ext_data),
    .need      (need),
    .ext_addr  (ext_addr),
    .dout      (dat_out),
    .oe        (dat_oe),
    .rd_n      (ext_rd_n),
    .wr_n      (ext_wr_n),
    .lane_n    (lane_n),
    .rdata     (rsp_rdata)
  );

  assign ext_data  = dat_oe ? dat_out : 'z;
  assign req_ready = (st == ST_DONE);
  assign ext_uds_n = lane_n[1];
  assign ext_lds_n = lane_n[0];

endmodule

// File: rtl/membus_bridge_chk.sv
module membus_bridge_chk #(
  parameter int AWE = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic [AWE-1:0] ext_addr,
  input logic           ext_rd_n,
  input logic           ext_wr_n,
  input logic           ext_uds_n,
  input logic           ext_lds_n,
  input logic           dat_oe
);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> (!ext_wr_n || $past(!ext_wr_n)));

  a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> dat_oe);

  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n && $past(!ext_rd_n)) |-> $stable(ext_addr));

  a_r2_a0_low: assert property (@(posedge clk) disable iff (!rst_n)
    ext_addr[0] == 1'b0);

  a_r6_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_n && ext_wr_n) |-> (ext_uds_n && ext_lds_n));

  a_r6_lane_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> (!ext_uds_n || !ext_lds_n));

endmodule

bind membus_bridge membus_bridge_chk #(.AWE(AWE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ext_addr  (ext_addr),
  .ext_rd_n  (ext_rd_n),
  .ext_wr_n  (ext_wr_n),
  .ext_uds_n (ext_uds_n),
  .ext_lds_n (ext_lds_n),
  .dat_oe    (dat_oe)
);

// File: tb/sim_membus_bridge.sv
module sim_membus_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic [23:0] ext_addr;
  wire  [15:0] ext_data;
  logic        ext_rd_n, ext_wr_n, ext_uds_n, ext_lds_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int cur_w = 15;

  logic [15:0] mem    [0:255];
  logic [15:0] shadow [0:255];

  always #10 clk = ~clk;

  membus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
    .cfg_wait(cfg_wait), .ext_addr(ext_addr), .ext_data(ext_data),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_uds_n(ext_uds_n),
    .ext_lds_n(ext_lds_n)
  );

  // memory model
  assign ext_data = (!ext_rd_n) ? mem[ext_addr[8:1]] : 16'hzzzz;

  always @(negedge clk) begin
    if (!ext_wr_n) begin
      if (!ext_lds_n) mem[ext_addr[8:1]][7:0]  <= ext_data[7:0];
      if (!ext_uds_n) mem[ext_addr[8:1]][15:8] <= ext_data[15:8];
    end
  end

  // bus cycle monitor
  int          n_ep = 0;
  logic        ep_a1    [0:3];
  logic [1:0]  ep_lanes [0:3];
  logic [21:0] ep_word  [0:3];
  int          ep_len   [0:3];
  int          cur_len = 0;
  bit          prev_strb = 1'b0;
  bit          prev_wr = 1'b0;
  logic [15:0] last_wd = '0;
  int          hold_bad = 0;

  always @(negedge clk) begin
    bit strb;
    strb = !ext_rd_n || !ext_wr_n;
    if (strb && !prev_strb) begin
      if (n_ep < 4) begin
        ep_a1[n_ep]    = ext_addr[1];
        ep_lanes[n_ep] = {~ext_uds_n, ~ext_lds_n};
        ep_word[n_ep]  = ext_addr[23:2];
      end
      n_ep++;
      cur_len = 0;
    end
    if (strb) cur_len++;
    if (!strb && prev_strb && n_ep >= 1 && n_ep <= 4) ep_len[n_ep-1] = cur_len;
    if (prev_wr && ext_wr_n && ext_data !== last_wd) hold_bad++;
    if (!ext_wr_n) last_wd = ext_data;
    prev_wr   = !ext_wr_n;
    prev_strb = strb;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input bit mid_cfg, input logic [3:0] cfgv);
    logic [3:0]  bee;
    logic [1:0]  nd;
    int          n, k, w, e;
    bit          got;
    logic [31:0] rd, exp_rd;
    logic [7:0]  wi;
    bee = (be == 4'h0) ? 4'hF : be;
    nd  = {|bee[3:2], |bee[1:0]};
    n   = int'(nd[0]) + int'(nd[1]);
    w   = cur_w;
    wi  = {a[8:2], 1'b0};
    n_ep = 0; hold_bad = 0;
    req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
    k = 0; got = 1'b0; rd = '0;
    while (!got && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 2 && mid_cfg) begin cfg_we = 1'b1; cfg_wait = cfgv; end
      else cfg_we = 1'b0;
      if (req_ready) begin got = 1'b1; rd = rsp_rdata; req_valid = 1'b0; end
    end
    cfg_we = 1'b0;
    req_valid = 1'b0;
    if (mid_cfg) cur_w = int'(cfgv);
    // R3: completion timing from acceptance
    chk(k == n * (w + 2) + 1, "R3 cycles", 32'(k), 32'(n * (w + 2) + 1));
    // R5: number of bus cycles
    chk(n_ep == n, "R5 bus cycles", 32'(n_ep), 32'(n));
    for (int i = 0; i < n && i < n_ep; i++) begin
      e = (i == 0 && nd[0]) ? 0 : 1;
      chk(ep_a1[i] == e[0], "R2 half order", 32'(ep_a1[i]), 32'(e));
      chk(ep_word[i] == a[23:2], "R2 address", 32'(ep_word[i]), 32'(a[23:2]));
      chk(ep_lanes[i] == bee[2*e +: 2], "R6 lanes", 32'(ep_lanes[i]), 32'(bee[2*e +: 2]));
      chk(ep_len[i] == w + 1, "R3 strobe length", 32'(ep_len[i]), 32'(w + 1));
    end
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (bee[b]) shadow[wi + 8'(b / 2)][8*(b % 2) +: 8] = wd[8*b +: 8];
      chk(mem[wi] == shadow[wi], "R7 write low", 32'(mem[wi]), 32'(shadow[wi]));
      chk(mem[wi+1] == shadow[wi+1], "R7 write high", 32'(mem[wi+1]), 32'(shadow[wi+1]));
      chk(hold_bad == 0, "R7 data hold", 32'(hold_bad), 32'd0);
    end else begin
      exp_rd = {nd[1] ? shadow[wi+1] : 16'h0, nd[0] ? shadow[wi] : 16'h0};
      chk(rd == exp_rd, "R9 read data", rd, exp_rd);
    end
    @(negedge clk);
  endtask

  task automatic set_wait(input int w);
    cfg_we = 1'b1; cfg_wait = 4'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_w = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 37 + 5);
      shadow[i] = 16'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ext_rd_n && ext_wr_n, "R1 strobes in reset", {ext_rd_n, ext_wr_n}, 2'b11);
    chk(ext_uds_n && ext_lds_n, "R1 lanes in reset", {ext_uds_n, ext_lds_n}, 2'b11);
    chk(!req_ready, "R1 ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ext_rd_n && ext_wr_n && !req_ready, "R1 idle after reset",
        {ext_rd_n, ext_wr_n, req_ready}, 3'b110);

    // R4: slow reset count of 15; upper address bits set (R2)
    access(1'b1, 32'hA5_3FC0_10, 32'hCAFE_1234, 4'hF, 1'b0, 4'h0);
    access(1'b0, 32'h5A_3FC0_10, 32'h0, 4'hF, 1'b0, 4'h0);
    access(1'b0, 32'hFF_3FC0_13, 32'h0, 4'b1100, 1'b0, 4'h0);

    // R5, R6, R7, R9: sweep enables at several fast counts
    foreach_w: for (int wsel = 0; wsel < 3; wsel++) begin
      set_wait((wsel == 0) ? 0 : (wsel == 1) ? 1 : 3);
      for (int be = 0; be < 16; be++) begin
        base = {8'(wsel * 17 + 3), 15'(be * 331), 9'(be * 8 + wsel * 128 + 4)};
        access(1'b1, base, {4'(be), 4'(wsel), 8'(be * 19), 16'(be * 4099 + wsel)},
               4'(be), 1'b0, 4'h0);
        access(1'b0, base, 32'h0, 4'hF, 1'b0, 4'h0);
        access(1'b0, base, 32'h0, 4'(be), 1'b0, 4'h0);
      end
    end

    // R4: load during a transaction applies only afterwards
    set_wait(3);
    access(1'b0, 32'h0000_0040, 32'h0, 4'hF, 1'b1, 4'h1);
    access(1'b1, 32'h0000_0044, 32'h1357_9BDF, 4'b0011, 1'b0, 4'h0);
    access(1'b0, 32'h0000_0044, 32'h0, 4'hF, 1'b0, 4'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule